// File: doc/BRIEF.md
# Interrupt Source State Controller

This block keeps the state of a parameterised group of interrupt sources and turns that state into presentation requests for a downstream presentation layer. Each source is fixed at build time as edge-signalled or level-signalled. Each source has a routing entry: a destination server, a priority and a saved priority. A priority of all ones masks the source. Four status bits per source (asserted, sent, rejected, masked-pending) carry the recovery rules for the two source kinds.

The presentation layer sends three kinds of notice back. A reject returns a global source number it could not take. An end-of-interrupt (EOI) reports a global source number it has finished with. A resend strobe asks every source to re-check itself. The block converts global numbers to local indices by subtracting a base offset. A number outside the block's range is ignored.

Only one request is outstanding at a time, on a valid/ready pair. When several sources wait, the lowest local index goes first. The request carries the global number (base plus index), the server, the current priority and the saved priority.

Top module: `isc_top`

## Requirements
- R1: After reset no request is valid and every source's priority is all ones (masked): an edge pulse or an asserted level input produces no request.
- R2: A request's number is BASE plus the local index. A reject or EOI number equal to BASE+i addresses source i. Numbers outside BASE..BASE+NSRC-1 have no effect.
- R3: An edge pulse on an unmasked edge source produces exactly one request carrying that source's server, priority and saved priority.
- R4: An edge pulse on a masked edge source sets masked-pending and makes no request. A later routing write with a priority other than all ones presents the source once and clears the bit. A write that keeps the source masked leaves it pending.
- R5: The level check presents a level source only when its priority is not all ones, asserted is set and sent is clear, and it sets sent. While sent stays set, no further request follows, even on resend.
- R6: A routing write replaces server, priority and saved priority. Later requests carry the new values. For a level source the write runs the level check.
- R7: A reject of an edge source sets rejected. A resend clears it and re-presents the source if unmasked; a second resend presents nothing. A rejected source that is masked at resend time is dropped.
- R8: A reject of a level source clears sent without re-presenting. The next resend runs the level check and re-presents a still-asserted source.
- R9: An EOI of a level source clears sent and runs the level check, so a still-asserted input re-presents and a deasserted one does not. An EOI of an edge source has no effect.
- R10: Waiting sources are issued in ascending index order, one per handshake. While ready is low, a valid request holds all of its fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NSRC | Per source: a one-cycle pulse for edge sources, the line level for level sources |
| wr_en | input | 1 | Routing entry write strobe |
| wr_idx | input | $clog2(NSRC) | Local index of the entry to write |
| wr_server | input | SRV_W | New destination server |
| wr_prio | input | 8 | New priority (all ones masks) |
| wr_saved | input | 8 | New saved priority |
| rej_valid | input | 1 | Reject strobe |
| rej_num | input | NUM_W | Global number being rejected |
| eoi_valid | input | 1 | EOI strobe |
| eoi_num | input | NUM_W | Global number being completed |
| resend | input | 1 | Resend strobe for all sources |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Presentation layer accepts the request |
| req_server | output | SRV_W | Destination server of the request |
| req_num | output | NUM_W | Global source number of the request |
| req_prio | output | 8 | Priority of the request |
| req_saved | output | 8 | Saved priority of the request |

## Verification
The bench checks the masked paths. An edge pulse on a masked source must survive until unmasking. A design that drops masked-pending loses the interrupt, and one that presents on a masked write gives a request at priority all ones. Rejects and resends are checked for both kinds of source. A level source that re-presents right after a reject would cause a request storm. A rejected edge source that is not cleared on resend would be presented again on every resend. The bench also checks EOIs with numbers just outside the range and with the base missing. It checks three sources triggered in the same cycle, with ready held low, to catch a wrong order or a request that changes while it waits.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int PRIO_W = 8;
  typedef logic [PRIO_W-1:0] prio_t;
  localparam prio_t PRIO_OFF = '1;

  function automatic logic prio_masked(input prio_t p);
    return p == PRIO_OFF;
  endfunction
endpackage

// File: rtl/isc_cell.sv
module isc_cell
  import isc_pkg::*;
#(
  parameter bit IS_LEVEL = 1'b0
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  sig,
  input  logic  wr_hit,
  input  prio_t wr_prio,
  input  logic  rej_hit,
  input  logic  eoi_hit,
  input  logic  resend,
  input  logic  take,
  output logic  want,
  output prio_t prio
);
  prio_t prio_q, p_n;
  logic  want_q, w_n;
  logic  asrt_q, asrt_n, sent_q, sent_n, rej_q, rej_n, mpend_q, mpend_n;
  logic  masked;

  always_comb begin
    p_n     = wr_hit ? wr_prio : prio_q;
    masked  = prio_masked(p_n);
    w_n     = want_q & ~take;
    asrt_n  = asrt_q;
    sent_n  = sent_q;
    rej_n   = rej_q;
    mpend_n = mpend_q;
    if (IS_LEVEL) begin
      asrt_n = sig;
      if (rej_hit || eoi_hit) sent_n = 1'b0;
      // the level check runs on input change, write, EOI and resend; not on reject
      if ((sig != asrt_q) || wr_hit || eoi_hit || resend) begin
        if (!masked && asrt_n && !sent_n) begin
          sent_n = 1'b1;
          w_n    = 1'b1;
        end
      end
    end else begin
      if (rej_hit) rej_n = 1'b1;
      if (sig) begin
        if (masked) mpend_n = 1'b1;
        else        w_n     = 1'b1;
      end
      if (wr_hit && mpend_n && !masked) begin
        mpend_n = 1'b0;
        w_n     = 1'b1;
      end
      if (resend && rej_n) begin
        rej_n = 1'b0;
        if (!masked) w_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prio_q  <= PRIO_OFF;
      want_q  <= 1'b0;
      asrt_q  <= 1'b0;
      sent_q  <= 1'b0;
      rej_q   <= 1'b0;
      mpend_q <= 1'b0;
    end else begin
      prio_q  <= p_n;
      want_q  <= w_n;
      asrt_q  <= asrt_n;
      sent_q  <= sent_n;
      rej_q   <= rej_n;
      mpend_q <= mpend_n;
    end
  end

  assign want = want_q;
  assign prio = prio_q;

  // R5: a source only starts waiting with an unmasked priority
  p_want_unmasked_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(want_q) |-> !prio_masked(prio_q));

  // R4: masked-pending only rises while the source is masked
  p_mpend_masked_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(mpend_q) |-> prio_masked(prio_q));
endmodule

// File: rtl/isc_pick.sv
module isc_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  want,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |want;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (want[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/isc_top.sv
module isc_top
  import isc_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int SRV_W = 4,
  parameter int NUM_W = 12,
  parameter int BASE = 16,
  parameter logic [NSRC-1:0] LEVEL_MASK = 8'hF0,
  localparam int IW = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  src_in,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [SRV_W-1:0] wr_server,
  input  logic [7:0]       wr_prio,
  input  logic [7:0]       wr_saved,
  input  logic             rej_valid,
  input  logic [NUM_W-1:0] rej_num,
  input  logic             eoi_valid,
  input  logic [NUM_W-1:0] eoi_num,
  input  logic             resend,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [SRV_W-1:0] req_server,
  output logic [NUM_W-1:0] req_num,
  output logic [7:0]       req_prio,
  output logic [7:0]       req_saved
);
  localparam int RW = SRV_W + PRIO_W;

  logic [NSRC-1:0] want_v, take_v, rej_hit, eoi_hit, wr_hit;
  prio_t           prio_v [NSRC];
  logic [RW-1:0]   route_mem [NSRC];
  logic            any, load;
  logic [IW-1:0]   pick_idx;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign rej_hit[i] = rej_valid && (rej_num == NUM_W'(BASE + i));
    assign eoi_hit[i] = eoi_valid && (eoi_num == NUM_W'(BASE + i));
    assign wr_hit[i]  = wr_en && (wr_idx == IW'(i));
    assign take_v[i]  = any && load && (pick_idx == IW'(i));
    isc_cell #(.IS_LEVEL(LEVEL_MASK[i])) u_cell (
      .clk(clk), .rst(rst), .sig(src_in[i]), .wr_hit(wr_hit[i]),
      .wr_prio(wr_prio), .rej_hit(rej_hit[i]), .eoi_hit(eoi_hit[i]),
      .resend(resend), .take(take_v[i]), .want(want_v[i]), .prio(prio_v[i])
    );
  end

  isc_pick #(.N(NSRC), .IW(IW)) u_pick (.want(want_v), .any(any), .idx(pick_idx));

  // routing memory: no reset, so it can map to RAM
  always_ff @(posedge clk) begin
    if (wr_en) route_mem[wr_idx] <= {wr_server, wr_saved};
  end

  assign load = !req_valid || req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid  <= 1'b0;
      req_server <= '0;
      req_num    <= '0;
      req_prio   <= '0;
      req_saved  <= '0;
    end else if (load) begin
      req_valid <= any;
      if (any) begin
        req_num                 <= NUM_W'(BASE) + NUM_W'(pick_idx);
        req_prio                <= prio_v[pick_idx];
        {req_server, req_saved} <= route_mem[pick_idx];
      end
    end
  end

  // R10: a stalled request holds its fields
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_num) && $stable(req_prio)
      && $stable(req_server) && $stable(req_saved));

  // R10: at most one source taken per handshake
  p_one_take_r10: assert property (@(posedge clk) disable iff (rst) $onehot0(take_v));

  // R2: issued numbers stay in the block's range
  p_num_range_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_num >= NUM_W'(BASE)) && (req_num < NUM_W'(BASE + NSRC)));
endmodule

// File: tb/isc_top_test.sv
`timescale 1ns/100ps
module isc_top_test;
  localparam int NSRC = 8, SRV_W = 4, NUM_W = 12, BASE = 16;

  logic clk = 0, rst = 1;
  logic [NSRC-1:0] src_in = '0;
  logic wr_en = 0; logic [2:0] wr_idx = 0; logic [SRV_W-1:0] wr_server = 0;
  logic [7:0] wr_prio = 0, wr_saved = 0;
  logic rej_valid = 0, eoi_valid = 0, resend = 0, req_ready = 0;
  logic [NUM_W-1:0] rej_num = 0, eoi_num = 0;
  logic req_valid; logic [SRV_W-1:0] req_server; logic [NUM_W-1:0] req_num;
  logic [7:0] req_prio, req_saved;
  int checks = 0, fails = 0; bit done = 0;

  always #2.5 clk = ~clk;

  isc_top #(.NSRC(NSRC), .SRV_W(SRV_W), .NUM_W(NUM_W), .BASE(BASE), .LEVEL_MASK(8'hF0)) uut (
    .clk(clk), .rst(rst), .src_in(src_in), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_server(wr_server), .wr_prio(wr_prio), .wr_saved(wr_saved),
    .rej_valid(rej_valid), .rej_num(rej_num), .eoi_valid(eoi_valid), .eoi_num(eoi_num),
    .resend(resend), .req_valid(req_valid), .req_ready(req_ready), .req_server(req_server),
    .req_num(req_num), .req_prio(req_prio), .req_saved(req_saved));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input int srv, input int pr, input int sv);
    wr_en = 1; wr_idx = 3'(idx); wr_server = SRV_W'(srv); wr_prio = 8'(pr); wr_saved = 8'(sv);
    @(negedge clk); wr_en = 0;
  endtask
  task automatic trig(input int idx);
    src_in[idx] = 1; @(negedge clk); src_in[idx] = 0;
  endtask
  task automatic rej(input int n);
    rej_valid = 1; rej_num = NUM_W'(n); @(negedge clk); rej_valid = 0;
  endtask
  task automatic eoi(input int n);
    eoi_valid = 1; eoi_num = NUM_W'(n); @(negedge clk); eoi_valid = 0;
  endtask
  task automatic do_resend();
    resend = 1; @(negedge clk); resend = 0;
  endtask

  task automatic expect_req(input int n, input int srv, input int pr, input int sv, input string tag);
    int k = 0;
    while (!req_valid && k < 20) begin @(negedge clk); k++; end
    chk(req_valid, {tag, " valid"}, int'(req_valid), 1);
    chk(req_num == NUM_W'(n), {tag, " num"}, int'(req_num), n);
    chk(req_server == SRV_W'(srv), {tag, " server"}, int'(req_server), srv);
    chk(req_prio == 8'(pr), {tag, " prio"}, int'(req_prio), pr);
    chk(req_saved == 8'(sv), {tag, " saved"}, int'(req_saved), sv);
    req_ready = 1; @(negedge clk); req_ready = 0;
  endtask

  task automatic expect_none(input int cyc, input string tag);
    int seen = 0;
    for (int c = 0; c < cyc; c++) begin @(negedge clk); if (req_valid) seen++; end
    chk(seen == 0, tag, seen, 0);
  endtask

  task automatic t_reset();
    chk(req_valid == 0, "R1 no request after reset", int'(req_valid), 0);
    src_in[4] = 1; expect_none(5, "R1 level source masked after reset"); src_in[4] = 0;
    trig(0); expect_none(5, "R1 edge source masked after reset");
  endtask
  task automatic t_mask();
    wr(0, 3, 5, 9); expect_req(16, 3, 5, 9, "R4 masked-pending presents on unmask");
    expect_none(4, "R4 single request");
    trig(1); wr(1, 2, 8'hFF, 0); expect_none(5, "R4 stays pending while masked");
    wr(1, 2, 2, 0); expect_req(17, 2, 2, 0, "R4 pending kept through masked write");
  endtask
  task automatic t_edge();
    wr(2, 1, 4, 4); expect_none(3, "R3 write alone does not present edge");
    trig(2); expect_req(18, 1, 4, 4, "R3 edge presents");
    expect_none(5, "R3 exactly one request");
  endtask
  task automatic t_write();
    wr(2, 7, 9, 3); trig(2); expect_req(18, 7, 9, 3, "R6 new routing used");
    src_in[5] = 1; expect_none(4, "R6 masked level waits");
    wr(5, 6, 3, 3); expect_req(21, 6, 3, 3, "R6 write runs level check");
    src_in[5] = 0; expect_none(3, "R6 drop level quiet");
  endtask
  task automatic t_level();
    wr(4, 2, 6, 6); expect_none(3, "R5 deasserted level quiet");
    src_in[4] = 1; expect_req(20, 2, 6, 6, "R5 level presents");
    expect_none(5, "R5 sent blocks repeat");
    do_resend(); expect_none(4, "R5 resend with sent set");
    eoi(20); expect_req(20, 2, 6, 6, "R9 EOI re-presents asserted level");
    src_in[4] = 0; @(negedge clk); eoi(20); expect_none(5, "R9 EOI on deasserted level");
  endtask
  task automatic t_range();
    src_in[4] = 1; expect_req(20, 2, 6, 6, "R2 level presents again");
    eoi(24); expect_none(4, "R2 EOI above range ignored");
    eoi(4); expect_none(4, "R2 EOI without base ignored");
    eoi(20); expect_req(20, 2, 6, 6, "R2 EOI BASE+4 hits source 4");
  endtask
  task automatic t_rej_level();
    rej(20); expect_none(6, "R8 reject level no immediate re-present");
    do_resend(); expect_req(20, 2, 6, 6, "R8 resend re-presents level");
    src_in[4] = 0; @(negedge clk); eoi(20); expect_none(3, "R8 cleanup");
  endtask
  task automatic t_rej_edge();
    trig(2); expect_req(18, 7, 9, 3, "R7 edge presents");
    rej(18); expect_none(4, "R7 reject alone quiet");
    do_resend(); expect_req(18, 7, 9, 3, "R7 resend re-presents edge");
    do_resend(); expect_none(4, "R7 second resend quiet");
    rej(18); wr(2, 7, 8'hFF, 0); do_resend(); expect_none(3, "R7 masked at resend dropped");
    wr(2, 7, 9, 0); expect_none(4, "R7 dropped source not pending");
  endtask
  task automatic t_eoi_edge();
    eoi(18); expect_none(4, "R9 EOI on edge no effect");
    trig(2); expect_req(18, 7, 9, 0, "R9 edge still works after EOI");
  endtask
  task automatic t_order();
    wr(3, 4, 1, 1);
    src_in[3] = 1; src_in[1] = 1; src_in[2] = 1; @(negedge clk); src_in[3:1] = '0;
    @(negedge clk); @(negedge clk);
    repeat (3) @(negedge clk);
    chk(req_valid && req_num == NUM_W'(17), "R10 held while stalled", int'(req_num), 17);
    expect_req(17, 2, 2, 0, "R10 first lowest index");
    expect_req(18, 7, 9, 0, "R10 second");
    expect_req(19, 4, 1, 1, "R10 third");
    expect_none(4, "R10 queue empty");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset(); t_mask(); t_edge(); t_write(); t_level(); t_range();
    t_rej_level(); t_rej_edge(); t_eoi_edge(); t_order();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(negedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run finished)");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule